// File: doc/BRIEF.md
# External Memory Interface Pin Arbiter

This block decides, pin by pin, who drives a bank of eight 8-bit I/O ports. Between external transfers, the pins carry their port latch values. On the low group of ports a pin can instead carry a crossbar value, when the crossbar has that pin selected. While an off-chip transfer is active, the external memory interface takes over four ports. It places the read and write strobes, the address latch enable, the address bytes and the data byte on those ports. On a read it releases the drivers of the data pins.

The configuration input selects three things: which group of four ports the interface uses, whether address and data share one port, and which address ranges count as off-chip. The block also produces a skip mask. This mask tells the crossbar which strobe pins to leave alone when the interface sits on the low ports. All outputs are registered, so a change at the inputs appears at the outputs one clock later. Pad output mode (open-drain or push-pull) is handled elsewhere and has no input here.

Top module: `emif_pin_arbiter`

## Requirements
- R1: While rst_ni is low, pin_o, pin_oe_o and skip_o are all zero.
- R2: With no claimed transfer, one cycle after the inputs are applied, every pin_oe_o bit is 1. Each pin of ports 0..3 shows xbar_val_i where xbar_sel_i is set and latch_i otherwise. Ports 4..7 show latch_i. Port p occupies bits [8p+7:8p].
- R3: cfg_i[3:2] is the memory mode: 00 never claims, 01 and 10 claim only for addr_i >= 16'h1000, and 11 claims every transfer with xfer_req_i high.
- R4: cfg_i[5]=0 places the interface on ports 0..3, and 1 places it on ports 4..7. The ports of the other group keep their R2 values.
- R5: On the first port of the selected group, a claimed transfer drives bit 7 with wr_n_i and bit 6 with rd_n_i. When cfg_i[4]=1 (multiplexed), it also drives bit 5 with ale_i. All other bits of that port keep their R2 values.
- R6: In non-multiplexed mode (cfg_i[4]=0), group ports 1, 2 and 3 carry addr_i[15:8], addr_i[7:0] and the data byte.
- R7: In multiplexed mode, group port 2 carries addr_i[15:8], and group port 1 keeps its R2 value. Group port 3 carries addr_i[7:0] with drivers on while ale_i=1, and the data byte while ale_i=0.
- R8: In the data phase, a claimed read (xfer_rd_i=1) turns off the drivers of all 8 data pins and shows 8'hFF on them. A claimed write drives wdata_i with drivers on. Every other claimed pin has its driver on.
- R9: skip_o bits 7 and 6 are 1 exactly when skip_en_i=1 and cfg_i[5]=0. Bit 5 also needs cfg_i[4]=1. Bits 4..0 are always 0. Transfers do not affect skip_o.
- R10: One cycle after xfer_req_i falls, every pin returns to its R2 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_i | input | 4 (bits 5:2) | Group select, multiplexed enable, memory mode |
| skip_en_i | input | 1 | Allow the strobe skip mask toward the crossbar |
| xfer_req_i | input | 1 | External transfer in progress |
| xfer_rd_i | input | 1 | Transfer is a read |
| addr_i | input | 16 | Transfer address |
| wdata_i | input | 8 | Write data |
| wr_n_i | input | 1 | Active-low write strobe |
| rd_n_i | input | 1 | Active-low read strobe |
| ale_i | input | 1 | Address latch enable |
| latch_i | input | 64 | Port latch values, ports 0..7 |
| xbar_val_i | input | 32 | Crossbar values, ports 0..3 |
| xbar_sel_i | input | 32 | Crossbar owns the pin, ports 0..3 |
| pin_o | output | 64 | Pin output values |
| pin_oe_o | output | 64 | Pin driver enables |
| skip_o | output | 8 | Skip mask for port 0 of the low group |

## Verification
The bench first applies idle patterns with random latch, crossbar and select values, so that every pin's route to its idle source is checked. It then sweeps the four memory modes with addresses just below and just above the 4 KB boundary, which separates the three claim rules. Claimed transfers cover each combination of port group, multiplexed or separate address, read or write, and the address and data phases of the shared port. The bench checks that the other group and the unused port stay on their idle sources. A mixed run with random values in every field follows, and a transfer is dropped at the end to confirm that the pins revert.

// File: rtl/emif_pkg.sv
package emif_pkg;
  typedef enum logic [1:0] {
    MM_ONCHIP     = 2'b00,
    MM_SPLIT      = 2'b01,
    MM_SPLIT_BANK = 2'b10,
    MM_OFFCHIP    = 2'b11
  } mem_mode_e;

  localparam int CFG_PSEL = 5;
  localparam int CFG_MUX  = 4;
endpackage

// File: rtl/emif_claim.sv
module emif_claim
  import emif_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int ONCHIP_LIMIT = 4096
) (
  input  logic              req_i,
  input  mem_mode_e         mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              claim_o
);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(ONCHIP_LIMIT);

  logic above;
  assign above = (addr_i >= LIMIT);

  always_comb begin
    unique case (mode_i)
      MM_ONCHIP:                claim_o = 1'b0;
      MM_SPLIT, MM_SPLIT_BANK:  claim_o = req_i & above;
      default:                  claim_o = req_i;
    endcase
  end
endmodule

// File: rtl/emif_port_map.sv
module emif_port_map #(
  parameter int PW     = 8,
  parameter int NP     = 8,
  parameter int GRP    = 4,
  parameter int ADDR_W = 16
) (
  input  logic              claim_i,
  input  logic              psel_i,
  input  logic              mux_i,
  input  logic              rd_i,
  input  logic              ale_i,
  input  logic              wr_n_i,
  input  logic              rd_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PW-1:0]     wdata_i,
  input  logic [NP*PW-1:0]  base_val_i,
  output logic [NP*PW-1:0]  val_o,
  output logic [NP*PW-1:0]  oe_o
);
  localparam int BIT_WR  = PW - 1;
  localparam int BIT_RD  = PW - 2;
  localparam int BIT_ALE = PW - 3;

  for (genvar p = 0; p < NP; p++) begin : g_port
    localparam int   K  = p % GRP;
    localparam logic HI = (p >= GRP);
    logic [PW-1:0] v, e;

    always_comb begin
      v = base_val_i[p*PW +: PW];
      e = '1;
      if (claim_i && (psel_i == HI)) begin
        if (K == 0) begin
          v[BIT_WR] = wr_n_i;
          v[BIT_RD] = rd_n_i;
          if (mux_i) v[BIT_ALE] = ale_i;
        end else if (K == 1) begin
          if (!mux_i) v = addr_i[ADDR_W-1 -: PW];
        end else if (K == 2) begin
          v = mux_i ? addr_i[ADDR_W-1 -: PW] : addr_i[PW-1:0];
        end else begin
          if (mux_i && ale_i) v = addr_i[PW-1:0];
          else if (rd_i) begin
            v = '1;
            e = '0;  // data pins become inputs on a read
          end else v = wdata_i;
        end
      end
    end

    assign val_o[p*PW +: PW] = v;
    assign oe_o[p*PW +: PW]  = e;
  end
endmodule

// File: rtl/emif_pin_arbiter.sv
module emif_pin_arbiter
  import emif_pkg::*;
#(
  parameter int PW           = 8,
  parameter int NP           = 8,
  parameter int GRP          = 4,
  parameter int ADDR_W       = 16,
  parameter int ONCHIP_LIMIT = 4096
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [5:2]           cfg_i,
  input  logic                 skip_en_i,
  input  logic                 xfer_req_i,
  input  logic                 xfer_rd_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [PW-1:0]        wdata_i,
  input  logic                 wr_n_i,
  input  logic                 rd_n_i,
  input  logic                 ale_i,
  input  logic [NP*PW-1:0]     latch_i,
  input  logic [GRP*PW-1:0]    xbar_val_i,
  input  logic [GRP*PW-1:0]    xbar_sel_i,
  output logic [NP*PW-1:0]     pin_o,
  output logic [NP*PW-1:0]     pin_oe_o,
  output logic [PW-1:0]        skip_o
);
  localparam int LOW_W  = GRP * PW;
  localparam int ALL_W  = NP * PW;
  localparam int DATA_K = 3;

  logic            psel, mux, claim;
  mem_mode_e       mode;
  logic [ALL_W-1:0] base_val, map_val, map_oe;
  logic [PW-1:0]   skip_d;

  assign psel = cfg_i[CFG_PSEL];
  assign mux  = cfg_i[CFG_MUX];
  assign mode = mem_mode_e'(cfg_i[3:2]);

  // idle source: crossbar on selected low pins, latch elsewhere
  assign base_val[LOW_W-1:0]     = (xbar_sel_i & xbar_val_i) | (~xbar_sel_i & latch_i[LOW_W-1:0]);
  assign base_val[ALL_W-1:LOW_W] = latch_i[ALL_W-1:LOW_W];

  emif_claim #(.ADDR_W(ADDR_W), .ONCHIP_LIMIT(ONCHIP_LIMIT)) u_claim (
    .req_i  (xfer_req_i),
    .mode_i (mode),
    .addr_i (addr_i),
    .claim_o(claim)
  );

  emif_port_map #(.PW(PW), .NP(NP), .GRP(GRP), .ADDR_W(ADDR_W)) u_map (
    .claim_i   (claim),
    .psel_i    (psel),
    .mux_i     (mux),
    .rd_i      (xfer_rd_i),
    .ale_i     (ale_i),
    .wr_n_i    (wr_n_i),
    .rd_n_i    (rd_n_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .base_val_i(base_val),
    .val_o     (map_val),
    .oe_o      (map_oe)
  );

  always_comb begin
    skip_d = '0;
    skip_d[PW-1] = skip_en_i & ~psel;
    skip_d[PW-2] = skip_en_i & ~psel;
    skip_d[PW-3] = skip_en_i & ~psel & mux;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_o    <= '0;
      pin_oe_o <= '0;
      skip_o   <= '0;
    end else begin
      pin_o    <= map_val;
      pin_oe_o <= map_oe;
      skip_o   <= skip_d;
    end
  end

  // R3
  onchip_no_claim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MM_ONCHIP) |=> (pin_o == $past(base_val)) && (&pin_oe_o));

  // R4
  other_group_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !psel |=> pin_o[ALL_W-1:LOW_W] == $past(latch_i[ALL_W-1:LOW_W]));

  // R5
  wr_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim && !psel) |=> pin_o[PW-1] == $past(wr_n_i));

  // R8
  read_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim && xfer_rd_i && !ale_i && !psel) |=> pin_oe_o[DATA_K*PW +: PW] == '0);

  // R9
  skip_high_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psel |=> skip_o == '0);
endmodule

// File: tb/emif_pin_arbiter_tb.sv
module emif_pin_arbiter_tb;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic [5:2]  cfg_i = '0;
  logic        skip_en_i = 0, xfer_req_i = 0, xfer_rd_i = 0;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        wr_n_i = 1, rd_n_i = 1, ale_i = 0;
  logic [63:0] latch_i = '0;
  logic [31:0] xbar_val_i = '0, xbar_sel_i = '0;
  logic [63:0] pin_o, pin_oe_o;
  logic [7:0]  skip_o;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct {
    logic [63:0] val;
    logic [63:0] oe;
    logic [7:0]  skip;
    string       tag;
  } exp_t;
  exp_t sb[$];

  emif_pin_arbiter u_dut (.*);

  always #2 clk_i = ~clk_i;

  function automatic exp_t model(string tag);
    exp_t r;
    int gb;
    bit mux, claim;
    r.tag = tag;
    for (int i = 0; i < 64; i++)
      r.val[i] = (i < 32 && xbar_sel_i[i]) ? xbar_val_i[i] : latch_i[i];
    r.oe = '1;
    mux = cfg_i[4];
    gb = cfg_i[5] ? 32 : 0;
    case (cfg_i[3:2])
      2'b00: claim = 0;
      2'b11: claim = xfer_req_i;
      default: claim = xfer_req_i && addr_i >= 16'h1000;
    endcase
    if (claim) begin
      r.val[gb+7] = wr_n_i;
      r.val[gb+6] = rd_n_i;
      if (mux) r.val[gb+5] = ale_i;
      if (!mux) begin
        r.val[gb+8 +: 8]  = addr_i[15:8];
        r.val[gb+16 +: 8] = addr_i[7:0];
      end else r.val[gb+16 +: 8] = addr_i[15:8];
      if (mux && ale_i) r.val[gb+24 +: 8] = addr_i[7:0];
      else if (xfer_rd_i) begin
        r.val[gb+24 +: 8] = 8'hFF;
        r.oe[gb+24 +: 8]  = 8'h00;
      end else r.val[gb+24 +: 8] = wdata_i;
    end
    r.skip = '0;
    if (skip_en_i && !cfg_i[5]) begin
      r.skip[7] = 1; r.skip[6] = 1;
      r.skip[5] = mux;
    end
    return r;
  endfunction

  task automatic drive(input logic [5:2] cfg, input bit req, input bit rd, input bit ale,
                       input logic [15:0] addr, input bit sk, input string tag);
    @(negedge clk_i);
    cfg_i = cfg; xfer_req_i = req; xfer_rd_i = rd; ale_i = ale;
    addr_i = addr; skip_en_i = sk;
    wdata_i = 8'($urandom); wr_n_i = 1'($urandom); rd_n_i = 1'($urandom);
    latch_i = {$urandom, $urandom};
    xbar_val_i = $urandom; xbar_sel_i = $urandom;
    sb.push_back(model(tag));
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk_i); #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        checks++;
        if (pin_o !== e.val || pin_oe_o !== e.oe || skip_o !== e.skip) begin
          fails++;
          $display("FAIL %s: val=%h oe=%h skip=%h expected val=%h oe=%h skip=%h",
                   e.tag, pin_o, pin_oe_o, skip_o, e.val, e.oe, e.skip);
        end
      end
    end
  end

  initial begin : watchdog
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: expired, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    latch_i = 64'h1234_5678_9ABC_DEF0;
    #9;
    checks++;  // R1 reset state
    if (pin_o !== '0 || pin_oe_o !== '0 || skip_o !== '0) begin
      fails++;
      $display("FAIL R1: val=%h oe=%h skip=%h expected all zero", pin_o, pin_oe_o, skip_o);
    end
    @(negedge clk_i); rst_ni = 1;

    for (int i = 0; i < 6; i++) drive(4'($urandom), 0, 1'($urandom), 0, 16'($urandom), 0, "R2 idle");
    // R3 mode sweep and boundary
    drive(4'b1100 | 4'b0000, 1, 0, 0, 16'hFFFF, 0, "R3 onchip");
    drive(4'b0001, 1, 0, 0, 16'h0FFF, 0, "R3 split below");
    drive(4'b0001, 1, 0, 0, 16'h1000, 0, "R3 split at boundary");
    drive(4'b0010, 1, 1, 0, 16'h0FFF, 0, "R3 bank below");
    drive(4'b0010, 1, 1, 0, 16'h1000, 0, "R3 bank at boundary");
    drive(4'b0011, 1, 0, 0, 16'h0000, 0, "R3 offchip low addr");
    // R6 non-mux, low group, write then read
    drive(4'b0011, 1, 0, 0, 16'hA55A, 0, "R6 nonmux write low");
    drive(4'b0011, 1, 1, 0, 16'h3C81, 0, "R8 nonmux read low");
    // R4 high group
    drive(4'b1011, 1, 0, 0, 16'h7E11, 0, "R4 nonmux write high");
    drive(4'b1011, 1, 1, 0, 16'h2222, 1, "R4 read high skip");
    // R7 mux phases
    drive(4'b0111, 1, 0, 1, 16'hBEEF, 0, "R7 mux addr phase");
    drive(4'b0111, 1, 0, 0, 16'hBEEF, 0, "R7 mux write data");
    drive(4'b0111, 1, 1, 1, 16'hC0DE, 0, "R7 mux read addr phase");
    drive(4'b0111, 1, 1, 0, 16'hC0DE, 0, "R8 mux read data");
    drive(4'b1111, 1, 0, 1, 16'h4321, 0, "R5 mux high ale");
    // R9 skip combos
    drive(4'b0000, 0, 0, 0, 16'h0000, 1, "R9 skip nonmux low");
    drive(4'b0100, 0, 0, 0, 16'h0000, 1, "R9 skip mux low");
    drive(4'b1100, 0, 0, 0, 16'h0000, 1, "R9 skip high");
    drive(4'b0111, 1, 0, 1, 16'hFFFF, 1, "R9 skip during transfer");
    // R10 revert after transfer
    drive(4'b0011, 1, 0, 0, 16'h9999, 0, "R10 claimed");
    drive(4'b0011, 0, 0, 0, 16'h9999, 0, "R10 released");
    for (int i = 0; i < 40; i++)
      drive(4'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 16'($urandom), 1'($urandom), "R5 mixed");
    @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule